// File: doc/BRIEF.md
# Length-Framed Packet Engine with Seeded CRC16

This block turns byte streams into framed packets and checks framed packets on the way back in. On the send side a request carries a payload length. The block then emits one marker item, the length byte, the payload bytes pulled from an upstream stream, and, when enabled, a two-byte CRC16. On the receive side an external start strobe opens a packet. The first byte after it is taken as the length, payload bytes are forwarded downstream, and the trailing CRC is checked. The block reports each packet end with single-cycle status pulses, and it can raise a request for an acknowledge packet.

The CRC start value comes from a programmable seed. The sender computes its CRC from either that seed or zero, chosen by a configuration bit. The receiver accepts a packet whose CRC matches either of the two start values, so both kinds of sender work with one receiver. All byte streams use valid/ready handshakes. Detecting the start of a packet on the air, and everything below the byte level, is handled elsewhere.

Top module: `pkt_framer`

## Requirements
- R1: A send request with length L of at most MAX_LEN (40) produces items in this order. First comes one marker item with `tx_out_sop`=1 and data 0x00. Then come the length byte L, the L payload bytes in arrival order, and, when `cfg_crc_en`=1, the CRC low byte and then the CRC high byte. Only the marker item has `tx_out_sop`=1.
- R2: The CRC16 uses the polynomial x^16+x^15+x^2+1. It is processed least significant bit first in reflected form (constant 0xA001), starts from the selected seed, and has no final inversion. It covers the payload bytes only, not the length byte.
- R3: The sender starts its CRC from `cfg_crc_seed` when `cfg_tx_zero_seed`=0 and from 0x0000 when it is 1.
- R4: A send request whose length is above MAX_LEN is consumed and produces no output item.
- R5: After `rx_sop`, the next accepted byte is the length. The L following bytes appear on `rx_out`. `rx_done` pulses for one cycle in the cycle after the final byte is accepted: the final byte is the last payload byte, or the CRC high byte when the CRC is enabled.
- R6: With the CRC enabled, `rx_crc_ok` pulses together with `rx_done` when the received CRC ({high,low}) equals the payload CRC computed from `cfg_crc_seed` or from zero. Otherwise `rx_done` pulses alone, with `rx_err` low.
- R7: With the CRC disabled, no CRC bytes are expected, and every packet that completes normally reports `rx_crc_ok`=1.
- R8: An `rx_sop` that arrives while a packet is open ends that packet with `rx_done` and `rx_err` pulsing together. Capture then restarts, and the next byte is the new length.
- R9: A received length above MAX_LEN ends the packet at once with `rx_done` and `rx_err`. Bytes that follow it are accepted and dropped, and none reaches `rx_out`.
- R10: `rx_ack_req` pulses with `rx_done` exactly when the packet completed with `rx_crc_ok`=1 and `rx_err`=0 while `cfg_ack_en`=1, and at no other time.
- R11: Under backpressure, a pending marker, length or CRC output stays valid and unchanged. Receive payload acceptance follows `rx_out_ready`.
- R12: After reset `tx_req_ready`=1, `tx_out_valid`=0, and all receive status pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_crc_en | input | 1 | Append and check CRC16 |
| cfg_crc_seed | input | 16 | Programmable CRC start value |
| cfg_tx_zero_seed | input | 1 | Sender starts its CRC from zero |
| cfg_ack_en | input | 1 | Enable acknowledge requests |
| tx_req_valid | input | 1 | Send request valid |
| tx_req_ready | output | 1 | Sender idle, request taken |
| tx_req_len | input | 8 | Payload length of the request |
| tx_in_valid | input | 1 | Payload byte valid |
| tx_in_ready | output | 1 | Payload byte taken |
| tx_in_data | input | 8 | Payload byte |
| tx_out_valid | output | 1 | Framed item valid |
| tx_out_ready | input | 1 | Framed item taken |
| tx_out_data | output | 8 | Framed byte |
| tx_out_sop | output | 1 | Item is the start marker |
| rx_sop | input | 1 | Start-of-packet strobe |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_ready | output | 1 | Received byte taken |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Payload byte valid |
| rx_out_ready | input | 1 | Payload byte taken |
| rx_out_data | output | 8 | Payload byte |
| rx_done | output | 1 | Packet ended (pulse) |
| rx_crc_ok | output | 1 | Packet CRC good (pulse) |
| rx_err | output | 1 | Packet aborted or length rejected (pulse) |
| rx_ack_req | output | 1 | Request to send an acknowledge (pulse) |

## Verification
The hardest case to reach is a start strobe that lands inside an open packet. The stimulus has to stop partway through the payload and then issue the strobe with no byte in flight. A directed sequence does this. It then feeds a complete packet straight away, to show that the restart takes the next byte as a length. The acceptance of a zero-seed CRC by a receiver programmed with a nonzero seed also needs its own packets. These are built in the bench with a CRC computed from zero, alongside random packets that use either seed or a corrupted CRC.

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int MAX_LEN = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_crc_en,
  input  logic [15:0] cfg_crc_seed,
  input  logic        cfg_tx_zero_seed,
  input  logic        cfg_ack_en,
  input  logic        tx_req_valid,
  output logic        tx_req_ready,
  input  logic [7:0]  tx_req_len,
  input  logic        tx_in_valid,
  output logic        tx_in_ready,
  input  logic [7:0]  tx_in_data,
  output logic        tx_out_valid,
  input  logic        tx_out_ready,
  output logic [7:0]  tx_out_data,
  output logic        tx_out_sop,
  input  logic        rx_sop,
  input  logic        rx_in_valid,
  output logic        rx_in_ready,
  input  logic [7:0]  rx_in_data,
  output logic        rx_out_valid,
  input  logic        rx_out_ready,
  output logic [7:0]  rx_out_data,
  output logic        rx_done,
  output logic        rx_crc_ok,
  output logic        rx_err,
  output logic        rx_ack_req
);
  localparam logic [7:0] MAXL = 8'(MAX_LEN);

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // ---------------- transmit ----------------
  typedef enum logic [2:0] {T_IDLE, T_SOP, T_LEN, T_PAY, T_CRCL, T_CRCH} tst_t;
  tst_t        ts, tend;
  logic [7:0]  tlen, tleft;
  logic [15:0] tcrc;
  logic        tcen;
  logic        tfire;

  assign tx_req_ready = (ts == T_IDLE);
  assign tx_out_sop   = (ts == T_SOP);
  assign tx_out_valid = (ts == T_PAY) ? tx_in_valid : (ts != T_IDLE);
  assign tx_in_ready  = (ts == T_PAY) && tx_out_ready;
  assign tfire        = tx_out_valid && tx_out_ready;
  assign tend         = tcen ? T_CRCL : T_IDLE;

  always_comb begin
    case (ts)
      T_LEN:   tx_out_data = tlen;
      T_PAY:   tx_out_data = tx_in_data;
      T_CRCL:  tx_out_data = tcrc[7:0];
      T_CRCH:  tx_out_data = tcrc[15:8];
      default: tx_out_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts    <= T_IDLE;
      tlen  <= '0;
      tleft <= '0;
      tcrc  <= '0;
      tcen  <= 1'b0;
    end else begin
      case (ts)
        T_IDLE: if (tx_req_valid && tx_req_len <= MAXL) begin
          ts    <= T_SOP;
          tlen  <= tx_req_len;
          tleft <= tx_req_len;
          tcen  <= cfg_crc_en;
          tcrc  <= cfg_tx_zero_seed ? 16'h0000 : cfg_crc_seed;
        end
        T_SOP:  if (tfire) ts <= T_LEN;
        T_LEN:  if (tfire) ts <= (tleft == 8'd0) ? tend : T_PAY;
        T_PAY:  if (tfire) begin
          tcrc  <= crc_byte(tcrc, tx_in_data);
          tleft <= tleft - 8'd1;
          if (tleft == 8'd1) ts <= tend;
        end
        T_CRCL: if (tfire) ts <= T_CRCH;
        T_CRCH: if (tfire) ts <= T_IDLE;
        default: ts <= T_IDLE;
      endcase
    end
  end

  assert_marker_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_sop && tx_out_valid && tx_out_ready) |=> !tx_out_sop);
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready && ts != T_PAY) |=> (tx_out_valid && $stable(tx_out_data)));
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts != T_IDLE) |-> (tlen <= MAXL));

  // ---------------- receive ----------------
  typedef enum logic [2:0] {R_IDLE, R_LEN, R_PAY, R_CRCL, R_CRCH} rst_t;
  rst_t        rs;
  logic [7:0]  rleft, rlo;
  logic [15:0] crc_s, crc_z;
  logic        rfire, crc_match;

  assign rx_in_ready  = (rs == R_PAY) ? rx_out_ready : 1'b1;
  assign rx_out_valid = (rs == R_PAY) && rx_in_valid && !rx_sop;
  assign rx_out_data  = rx_in_data;
  assign rfire        = rx_in_valid && rx_in_ready && !rx_sop;
  assign crc_match    = ({rx_in_data, rlo} == crc_s) || ({rx_in_data, rlo} == crc_z);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs         <= R_IDLE;
      rleft      <= '0;
      rlo        <= '0;
      crc_s      <= '0;
      crc_z      <= '0;
      rx_done    <= 1'b0;
      rx_crc_ok  <= 1'b0;
      rx_err     <= 1'b0;
      rx_ack_req <= 1'b0;
    end else begin
      rx_done    <= 1'b0;
      rx_crc_ok  <= 1'b0;
      rx_err     <= 1'b0;
      rx_ack_req <= 1'b0;
      if (rx_sop) begin
        rs    <= R_LEN;
        crc_s <= cfg_crc_seed;
        crc_z <= 16'h0000;
        if (rs != R_IDLE) begin
          rx_done <= 1'b1;
          rx_err  <= 1'b1;
        end
      end else if (rfire) begin
        case (rs)
          R_LEN: begin
            if (rx_in_data > MAXL) begin
              rs      <= R_IDLE;
              rx_done <= 1'b1;
              rx_err  <= 1'b1;
            end else begin
              rleft <= rx_in_data;
              if (rx_in_data != 8'd0)  rs <= R_PAY;
              else if (cfg_crc_en)     rs <= R_CRCL;
              else begin
                rs         <= R_IDLE;
                rx_done    <= 1'b1;
                rx_crc_ok  <= 1'b1;
                rx_ack_req <= cfg_ack_en;
              end
            end
          end
          R_PAY: begin
            crc_s <= crc_byte(crc_s, rx_in_data);
            crc_z <= crc_byte(crc_z, rx_in_data);
            rleft <= rleft - 8'd1;
            if (rleft == 8'd1) begin
              if (cfg_crc_en) rs <= R_CRCL;
              else begin
                rs         <= R_IDLE;
                rx_done    <= 1'b1;
                rx_crc_ok  <= 1'b1;
                rx_ack_req <= cfg_ack_en;
              end
            end
          end
          R_CRCL: begin
            rlo <= rx_in_data;
            rs  <= R_CRCH;
          end
          R_CRCH: begin
            rs         <= R_IDLE;
            rx_done    <= 1'b1;
            rx_crc_ok  <= crc_match;
            rx_ack_req <= crc_match && cfg_ack_en;
          end
          default: rs <= R_IDLE;
        endcase
      end
    end
  end

  assert_err_ends_pkt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_done);
  assert_ok_not_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_ok |-> (rx_done && !rx_err));
  assert_ack_only_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack_req |-> (rx_crc_ok && $past(cfg_ack_en)));
  assert_no_fwd_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> (rs == R_PAY));
endmodule

// File: tb/test_pkt_framer.sv
`timescale 1ns/1ps
module test_pkt_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_crc_en = 1'b1, cfg_tx_zero_seed = 1'b0, cfg_ack_en = 1'b1;
  logic [15:0] cfg_crc_seed = 16'h1D0F;
  logic        tx_req_valid = 1'b0, tx_in_valid = 1'b0, tx_out_ready = 1'b1;
  logic [7:0]  tx_req_len = '0, tx_in_data = '0;
  logic        tx_req_ready, tx_in_ready, tx_out_valid, tx_out_sop;
  logic [7:0]  tx_out_data;
  logic        rx_sop = 1'b0, rx_in_valid = 1'b0, rx_out_ready = 1'b1;
  logic [7:0]  rx_in_data = '0;
  logic        rx_in_ready, rx_out_valid, rx_done, rx_crc_ok, rx_err, rx_ack_req;
  logic [7:0]  rx_out_data;

  always #2.5 clk = ~clk;

  pkt_framer i_pkt_framer (
    .clk(clk), .rst_n(rst_n),
    .cfg_crc_en(cfg_crc_en), .cfg_crc_seed(cfg_crc_seed),
    .cfg_tx_zero_seed(cfg_tx_zero_seed), .cfg_ack_en(cfg_ack_en),
    .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready), .tx_req_len(tx_req_len),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data), .tx_out_sop(tx_out_sop),
    .rx_sop(rx_sop), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(rx_in_data), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_data(rx_out_data), .rx_done(rx_done), .rx_crc_ok(rx_crc_ok),
    .rx_err(rx_err), .rx_ack_req(rx_ack_req)
  );

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] pay [0:63];
  logic [7:0] rxb [0:63];
  logic [7:0] tcap [0:127];
  logic       tsop [0:127];
  logic [7:0] rcap [0:63];
  int tn, rn, racc, ndone, nack, done_at;
  logic last_ok, last_err;

  task automatic check_eq(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] seed, input int n);
    logic [15:0] r;
    r = seed;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++)
        r = (r[0] ^ pay[k][b]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_done) begin ndone++; last_ok = rx_crc_ok; last_err = rx_err; done_at = racc; end
      if (rx_ack_req) nack++;
      if (tx_out_valid && tx_out_ready) begin tcap[tn] = tx_out_data; tsop[tn] = tx_out_sop; tn++; end
      if (rx_out_valid && rx_out_ready) begin rcap[rn] = rx_out_data; rn++; end
      if (rx_in_valid && rx_in_ready) racc++;
    end
  end

  task automatic tx_run(int len, bit zsel, bit cen, bit bp);
    int idx, bad;
    logic [15:0] c;
    cfg_crc_en = cen; cfg_tx_zero_seed = zsel;
    for (int i = 0; i < 64; i++) pay[i] = 8'($urandom);
    tn = 0; idx = 0;
    @(posedge clk); #1;
    tx_req_valid = 1'b1; tx_req_len = 8'(len);
    @(posedge clk); #1;
    tx_req_valid = 1'b0;
    for (int k = 0; k < 600; k++) begin
      tx_in_valid  = (idx < len) && (bp ? ($urandom % 3 != 0) : 1'b1);
      tx_in_data   = pay[idx % 64];
      tx_out_ready = bp ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
      if (tx_in_valid && tx_in_ready) idx++;
      if (tx_req_ready) break;
      @(posedge clk); #1;
    end
    tx_in_valid = 1'b0; tx_out_ready = 1'b1;
    if (len > 40) begin
      check_eq("R4", "items for oversize request", tn, 0);
      check_eq("R4", "sender idle after oversize request", tx_req_ready, 1);
    end else begin
      c = crc_ref(zsel ? 16'h0 : cfg_crc_seed, len);
      check_eq("R1", "item count", tn, 2 + len + (cen ? 2 : 0));
      check_eq("R1", "marker flag", tsop[0], 1);
      check_eq("R1", "marker data", tcap[0], 0);
      check_eq("R1", "length byte", tcap[1], len);
      bad = 0;
      for (int i = 0; i < len; i++) if (tcap[2+i] != pay[i] || tsop[2+i]) bad++;
      check_eq("R1", "payload mismatches", bad, 0);
      if (cen) begin
        check_eq(zsel ? "R3" : "R2", "crc low", tcap[2+len], c[7:0]);
        check_eq(zsel ? "R3" : "R2", "crc high", tcap[3+len], c[15:8]);
      end
    end
  endtask

  // mode: 0 good seed crc, 1 good zero crc, 2 corrupted crc
  function automatic int build_rx(int len, int mode, bit cen);
    logic [15:0] c;
    for (int i = 0; i < 64; i++) pay[i] = 8'($urandom);
    rxb[0] = 8'(len);
    for (int i = 0; i < len; i++) rxb[1+i] = pay[i];
    if (!cen) return 1 + len;
    c = crc_ref(mode == 1 ? 16'h0 : cfg_crc_seed, len);
    if (mode == 2) c = c ^ 16'h0100;
    rxb[1+len] = c[7:0];
    rxb[2+len] = c[15:8];
    return 3 + len;
  endfunction

  task automatic rx_clear();
    rn = 0; racc = 0; ndone = 0; nack = 0; done_at = -1; last_ok = 0; last_err = 0;
  endtask

  task automatic rx_strobe();
    @(posedge clk); #1; rx_sop = 1'b1;
    @(posedge clk); #1; rx_sop = 1'b0;
  endtask

  task automatic rx_feed(int n, bit bp);
    int i;
    i = 0;
    for (int k = 0; k < 800 && i < n; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      rx_in_valid  = bp ? ($urandom % 4 != 0) : 1'b1;
      rx_in_data   = rxb[i];
      rx_out_ready = bp ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
      if (rx_in_valid && rx_in_ready) i++;
    end
    @(posedge clk); #1;
    rx_in_valid = 1'b0; rx_out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic rx_good(string req, int len, int mode, bit cen, bit bp);
    int n, bad;
    cfg_crc_en = cen;
    n = build_rx(len, mode, cen);
    rx_clear();
    rx_strobe();
    rx_feed(n, bp);
    check_eq("R5", "done count", ndone, 1);
    check_eq("R5", "done right after last byte", done_at, n);
    check_eq("R5", "payload bytes out", rn, len);
    bad = 0;
    for (int i = 0; i < len; i++) if (rcap[i] != pay[i]) bad++;
    check_eq("R5", "payload mismatches", bad, 0);
    check_eq(req, "crc ok", last_ok, mode != 2);
    check_eq(req, "err", last_err, 0);
    check_eq("R10", "ack count", nack, (mode != 2 && cfg_ack_en) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_eq("R12", "req ready in reset", tx_req_ready, 1);
    check_eq("R12", "out valid in reset", tx_out_valid, 0);
    check_eq("R12", "status pulses in reset", {rx_done, rx_crc_ok, rx_err, rx_ack_req}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_eq("R12", "req ready after reset", tx_req_ready, 1);

    // transmit directed
    tx_run(5, 0, 1, 0);
    tx_run(12, 1, 1, 1);     // R3 and R11 under backpressure
    tx_run(0, 0, 1, 0);
    tx_run(40, 0, 0, 1);
    tx_run(41, 0, 1, 0);     // R4
    tx_run(200, 1, 1, 0);    // R4

    // receive directed
    cfg_ack_en = 1;
    rx_good("R6", 7, 0, 1, 0);
    rx_good("R6", 16, 1, 1, 1);   // zero-seed CRC accepted, R11 backpressure
    rx_good("R6", 3, 2, 1, 0);    // corrupted CRC
    rx_good("R7", 9, 0, 0, 0);    // CRC disabled
    rx_good("R6", 0, 0, 1, 0);
    rx_good("R7", 40, 0, 0, 1);
    cfg_ack_en = 0;
    rx_good("R10", 6, 0, 1, 0);
    cfg_ack_en = 1;

    // R8: abort mid-packet, then a full packet right after
    cfg_crc_en = 1;
    void'(build_rx(10, 0, 1));
    rx_clear();
    rx_strobe();
    rx_feed(4, 0);
    rx_strobe();
    @(posedge clk); #1;
    check_eq("R8", "abort done", ndone, 1);
    check_eq("R8", "abort err", last_err, 1);
    check_eq("R8", "abort no ack", nack, 0);
    begin
      int n;
      n = build_rx(4, 0, 1);
      rx_clear();
      rx_feed(n, 0);
      check_eq("R8", "restart done", ndone, 1);
      check_eq("R8", "restart crc ok", last_ok, 1);
      check_eq("R8", "restart payload", rn, 4);
    end

    // R9: oversize received length
    rxb[0] = 8'd41;
    for (int i = 1; i < 6; i++) rxb[i] = 8'($urandom);
    rx_clear();
    rx_strobe();
    rx_feed(6, 0);
    check_eq("R9", "reject done", ndone, 1);
    check_eq("R9", "reject err", last_err, 1);
    check_eq("R9", "reject at length byte", done_at, 1);
    check_eq("R9", "no payload forwarded", rn, 0);
    check_eq("R9", "no ack", nack, 0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      cfg_crc_seed = 16'($urandom);
      cfg_ack_en   = 1'($urandom % 2);
      if (it % 2 == 0)
        tx_run($urandom % 41, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      else
        rx_good("R6", $urandom % 41, $urandom % 3, 1'b1, 1'($urandom % 2));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
  end
endmodule